// File: doc/BRIEF.md
# Burst SRAM with Wrapping Address Counter

This block models a synchronous pipelined static RAM with its own burst address generator. Every clock it samples an external address, an advance/load select, a chip enable, a write enable, a set of per-lane write enables and a write data word. A load cycle captures the external address as the start of a burst and performs one access there. Each advance cycle that follows steps an internal counter and performs the next access of the same burst.

The counter steps only the two lowest address bits, so a burst circles through an aligned group of four words for as long as advance cycles continue. The upper bits stay fixed. Reads are pipelined, and their data appears one clock after the address cycle. Writes use late-write timing, so the data and lane enables for a write arrive one clock after the command.

A read that targets the word written by the immediately preceding command receives the freshly merged data. A deselect cycle ends the burst.

Top module: `burst_sram`

## Requirements
- R1: After reset, and after any cycle with `rst` high, `rd_valid_o` is 0 and no burst is active, so advance cycles perform no access until the next load.
- R2: A load cycle (`adv_i`=0, `ce_i`=1) captures `addr_i` as the burst start and accesses that address in the same cycle. The access is a write when `we_i`=1 and a read when `we_i`=0.
- R3: An advance cycle (`adv_i`=1) in an active burst ignores `addr_i`. It accesses the previous access address with bits [1:0] incremented modulo 4 and all higher bits unchanged, so a burst started at A+2 visits A+3, A, A+1, A+2.
- R4: Advance cycles may continue past four accesses, and the address keeps circling through the same aligned group of four.
- R5: A read access in cycle t drives `rd_valid_o`=1 with the word in `rd_data_o` after the clock edge that ends cycle t. `rd_valid_o` is 0 after any cycle without a read access.
- R6: For a write access in cycle t, the block takes the write data `wr_data_i` and lane enables `bwe_i` from cycle t+1.
- R7: Lane k of a word is bits [9k+8:9k], and `bwe_i[k]`=1 writes that lane. A write with `bwe_i` all zero leaves the stored word unchanged.
- R8: An advance cycle keeps the read/write type set by the load. `we_i` is ignored on advance cycles.
- R9: A deselect cycle (`adv_i`=0, `ce_i`=0) performs no access and ends the burst. Later advance cycles perform no access until the next load.
- R10: A read of the address written by the previous cycle's command returns the stored word merged with that write's enabled lanes.
- R11: `ce_i` is ignored on advance cycles, so the burst continues with `ce_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (8) | External word address, used on load cycles |
| adv_i | input | 1 | 1 = advance the burst counter, 0 = load or deselect |
| ce_i | input | 1 | Chip enable, active high, sampled on non-advance cycles |
| we_i | input | 1 | 1 = write burst, 0 = read burst, sampled on load cycles |
| bwe_i | input | LANES (4) | Lane write enables for the late write data |
| wr_data_i | input | LANES*LANE_W (36) | Late write data |
| rd_data_o | output | LANES*LANE_W (36) | Registered read data |
| rd_valid_o | output | 1 | High for one cycle per read access, one clock after it |

## Verification
A read can fall in the same cycle as the commit of the previous cycle's late write to the same word. The bench provokes this by issuing a write command and then, in the next cycle, a read load of that address while presenting partial lane enables with the late data. It judges the result by requiring the read to return the old word with only the enabled lanes replaced, and then re-reads the word to confirm the commit. Wrap-around reads after a burst write also overlap the final late write with the deselect that ends the burst, which checks that the last word is still committed.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // Width of the part of the address that the burst counter steps.
    localparam int unsigned STEP_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Next position inside an aligned group of four words.
    function automatic logic [STEP_W-1:0] wrap_step(input logic [STEP_W-1:0] pos);
        return pos + STEP_W'(1);
    endfunction

    function automatic op_e op_of(input logic is_write);
        return is_write ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    input  logic              ce_i,
    input  logic              we_i,
    output op_e               acc_op_o,
    output logic [ADDR_W-1:0] acc_addr_o
);

    localparam int unsigned HI_W = ADDR_W - STEP_W;

    logic              burst_on_q;
    logic              burst_wr_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [ADDR_W-1:0] step_addr;

    assign step_addr = {last_addr_q[ADDR_W-1 -: HI_W], wrap_step(last_addr_q[STEP_W-1:0])};

    always_comb begin
        acc_op_o   = OP_IDLE;
        acc_addr_o = last_addr_q;
        if (!adv_i) begin
            if (ce_i) begin
                acc_op_o   = op_of(we_i);
                acc_addr_o = addr_i;
            end
        end else if (burst_on_q) begin
            acc_op_o   = op_of(burst_wr_q);
            acc_addr_o = step_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_on_q  <= 1'b0;
            burst_wr_q  <= 1'b0;
            last_addr_q <= '0;
        end else if (!adv_i) begin
            burst_on_q <= ce_i;
            if (ce_i) begin
                burst_wr_q  <= we_i;
                last_addr_q <= addr_i;
            end
        end else if (burst_on_q) begin
            last_addr_q <= step_addr;
        end
    end

endmodule

// File: rtl/late_write_pipe.sv
module late_write_pipe
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               acc_op_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              pend_valid_o,
    output logic [ADDR_W-1:0] pend_addr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid_o <= 1'b0;
            pend_addr_o  <= '0;
        end else begin
            pend_valid_o <= (acc_op_i == OP_WRITE);
            if (acc_op_i == OP_WRITE) begin
                pend_addr_o <= acc_addr_i;
            end
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [LANES*LANE_W-1:0] wr_data_i,
    input  logic [LANES-1:0]        bwe_i,
    output logic [LANES*LANE_W-1:0] rd_data_o,
    output logic                    rd_valid_o
);

    localparam int unsigned WORD_W = LANES * LANE_W;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] merged_word;
    logic [WORD_W-1:0] rd_word;

    assign old_word = mem[wr_addr_i];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_word[g*LANE_W +: LANE_W] =
            bwe_i[g] ? wr_data_i[g*LANE_W +: LANE_W] : old_word[g*LANE_W +: LANE_W];
    end

    // A read of the word committed at this same edge sees the merged value.
    assign rd_word = (wr_en_i && (wr_addr_i == rd_addr_i)) ? merged_word : mem[rd_addr_i];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= merged_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                rd_data_o <= rd_word;
            end
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    adv_i,
    input  logic                    ce_i,
    input  logic                    we_i,
    input  logic [LANES-1:0]        bwe_i,
    input  logic [LANES*LANE_W-1:0] wr_data_i,
    output logic [LANES*LANE_W-1:0] rd_data_o,
    output logic                    rd_valid_o
);

    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .adv_i      (adv_i),
        .ce_i       (ce_i),
        .we_i       (we_i),
        .acc_op_o   (acc_op),
        .acc_addr_o (acc_addr)
    );

    late_write_pipe #(.ADDR_W(ADDR_W)) u_lwp (
        .clk          (clk),
        .rst          (rst),
        .acc_op_i     (acc_op),
        .acc_addr_i   (acc_addr),
        .pend_valid_o (pend_valid),
        .pend_addr_o  (pend_addr)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .rd_en_i    (acc_op == OP_READ),
        .rd_addr_i  (acc_addr),
        .wr_en_i    (pend_valid),
        .wr_addr_i  (pend_addr),
        .wr_data_i  (wr_data_i),
        .bwe_i      (bwe_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              adv_i,
    input logic              ce_i,
    input op_e               acc_op,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              pend_valid,
    input logic              rd_valid_o
);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && ce_i) |-> (acc_op != OP_IDLE && acc_addr == addr_i));

    assert_adv_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_i && acc_op != OP_IDLE) |->
            (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]) &&
             acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

    assert_type_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (adv_i && acc_op != OP_IDLE) |-> (acc_op == $past(acc_op)));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_READ) |=> rd_valid_o);

    assert_no_stray_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_op != OP_READ) |=> !rd_valid_o);

    assert_late_write_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_WRITE) |=> pend_valid);

    assert_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !ce_i) |=> (!rd_valid_o && !pend_valid));

    assert_one_result_R5: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid_o && pend_valid));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .adv_i      (adv_i),
    .ce_i       (ce_i),
    .acc_op     (acc_op),
    .acc_addr   (acc_addr),
    .pend_valid (pend_valid),
    .rd_valid_o (rd_valid_o)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          adv_i, ce_i, we_i;
    logic [3:0]    bwe_i;
    logic [DW-1:0] wr_data_i;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_sram dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .adv_i(adv_i), .ce_i(ce_i),
        .we_i(we_i), .bwe_i(bwe_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    typedef struct packed {
        logic          adv;
        logic          ce;
        logic          we;
        logic [AW-1:0] addr;
        logic [3:0]    bwe;
        logic [DW-1:0] wdata;
        logic          erv;
        logic [DW-1:0] erd;
    } vec_t;

    localparam logic [DW-1:0] D0 = 36'h1_1111_1111;
    localparam logic [DW-1:0] D1 = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] D2 = 36'h2_3456_789A;
    localparam logic [DW-1:0] D3 = 36'h9_8765_4321;
    localparam logic [DW-1:0] D4 = 36'h4_4444_4444;
    localparam logic [DW-1:0] PA = 36'hA_AAAA_AAAA;
    localparam logic [DW-1:0] MX = 36'hF_FAAB_FEAA; // D1 with lanes 0 and 2 from PA
    localparam logic [DW-1:0] P5 = 36'h5_5555_5555;

    localparam int NV = 19;
    // Each row: command of this cycle, late data for the previous command,
    // and the read result expected after this cycle's edge.
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b1, 8'h10, 4'h0, '0, 1'b0, '0}, // R2 write burst load at 0x10
        '{1'b1, 1'b1, 1'b1, 8'h00, 4'hF, D0, 1'b0, '0}, // R6 data for 0x10, step to 0x11
        '{1'b1, 1'b0, 1'b0, 8'h00, 4'hF, D1, 1'b0, '0}, // R11 ce low, R8 we low, step 0x12
        '{1'b1, 1'b1, 1'b1, 8'h00, 4'hF, D2, 1'b0, '0}, // step 0x13
        '{1'b1, 1'b1, 1'b0, 8'h00, 4'hF, D3, 1'b0, '0}, // R3 wrap to 0x10, still write
        '{1'b0, 1'b0, 1'b0, 8'h00, 4'hF, D4, 1'b0, '0}, // R9 deselect, last data 0x10
        '{1'b1, 1'b1, 1'b1, 8'h55, 4'hF, P5, 1'b0, '0}, // R9 advance after deselect: no access
        '{1'b0, 1'b1, 1'b0, 8'h12, 4'h0, '0, 1'b1, D2}, // R5 read load at A+2
        '{1'b1, 1'b1, 1'b1, 8'h77, 4'h0, '0, 1'b1, D3}, // R3 addr ignored, R8 we ignored
        '{1'b1, 1'b1, 1'b0, 8'h00, 4'h0, '0, 1'b1, D4}, // R3 wrap to 0x10
        '{1'b1, 1'b1, 1'b0, 8'h00, 4'h0, '0, 1'b1, D1}, // 0x11
        '{1'b1, 1'b1, 1'b0, 8'h00, 4'h0, '0, 1'b1, D2}, // R4 fifth access back at 0x12
        '{1'b0, 1'b1, 1'b1, 8'h11, 4'h0, '0, 1'b0, '0}, // write command to 0x11
        '{1'b0, 1'b1, 1'b0, 8'h11, 4'h5, PA, 1'b1, MX}, // R10 forward, R7 lanes 0 and 2
        '{1'b0, 1'b1, 1'b0, 8'h11, 4'h0, '0, 1'b1, MX}, // R7 merged word committed
        '{1'b0, 1'b1, 1'b1, 8'h13, 4'h0, '0, 1'b0, '0}, // write command to 0x13
        '{1'b0, 1'b0, 1'b0, 8'h00, 4'h0, P5, 1'b0, '0}, // R7 no lanes enabled
        '{1'b0, 1'b1, 1'b0, 8'h13, 4'h0, '0, 1'b1, D3}, // R7 word unchanged
        '{1'b0, 1'b0, 1'b0, 8'h00, 4'h0, '0, 1'b0, '0}  // R9 idle
    };

    task automatic drive(input logic a, input logic c, input logic w,
                         input logic [AW-1:0] ad, input logic [3:0] b,
                         input logic [DW-1:0] d);
        @(negedge clk);
        adv_i = a; ce_i = c; we_i = w; addr_i = ad; bwe_i = b; wr_data_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check_out(input string tag, input logic erv, input logic [DW-1:0] erd);
        checks++;
        if (rd_valid_o !== erv || (erv && rd_data_o !== erd)) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, rd_valid_o, rd_data_o, erv, erd);
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        adv_i = 1'b0; ce_i = 1'b0; we_i = 1'b0; addr_i = '0; bwe_i = '0; wr_data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset state", 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1: advance straight after reset performs no access
        drive(1'b1, 1'b1, 1'b0, 8'h10, 4'h0, '0);
        check_out("R1 advance after reset", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].adv, TBL[i].ce, TBL[i].we, TBL[i].addr, TBL[i].bwe, TBL[i].wdata);
            check_out($sformatf("table vector %0d (R2-R10 per row)", i), TBL[i].erv, TBL[i].erd);
        end

        // R11: read burst continues with ce low
        drive(1'b0, 1'b1, 1'b0, 8'h12, 4'h0, '0);
        check_out("R5 read load 0x12", 1'b1, D2);
        drive(1'b1, 1'b0, 1'b0, 8'h00, 4'h0, '0);
        check_out("R11 advance with ce low", 1'b1, D3);

        // R1: reset in the middle of a burst ends it
        @(negedge clk);
        rst = 1'b1;
        adv_i = 1'b1; ce_i = 1'b1;
        @(posedge clk);
        #1;
        check_out("R1 valid low during reset", 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 8'h00, 4'h0, '0);
        check_out("R1 burst cleared by reset", 1'b0, '0);

        // R10 with a write burst: read the last written word right after it
        drive(1'b0, 1'b1, 1'b1, 8'h23, 4'h0, '0);
        check_out("R6 write command no read", 1'b0, '0);
        drive(1'b0, 1'b1, 1'b0, 8'h23, 4'hF, D2);
        check_out("R10 forward full word", 1'b1, D2);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 4'h0, '0);
        check_out("R9 deselect after read", 1'b0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule